// File: doc/BRIEF.md
# Phase Dot-Product Engine for a Resampling Filter

This block computes one output sample of a polyphase resampler. After a start pulse it streams twenty sample words from a data memory and the twenty taps of a single filter phase from a coefficient memory. It multiplies each pair at full 64-bit precision and adds the products into a 64-bit accumulator. The scaled sum is then returned as one signed 32-bit word, and a one-cycle done pulse marks it valid.

The taps of a phase can be walked upward or downward in memory. A direction flag inside the phase-select word picks the way. Mirrored phases of a symmetric filter bank can therefore reuse the stored taps of their partner, and only half of the bank needs to be kept. Both memory ports are plain synchronous reads with one cycle of latency. The engine issues one tap read per clock.

Top module: `fir_phase_mac`

## Requirements
- R1: `start` is accepted on a rising edge when the engine is idle, or in the cycle where `done` is high. Exactly 20 tap products go into each output. `done` is high for exactly one cycle, set by the 22nd rising edge after the accepting edge.
- R2: The data read address begins at `data_base` and rises by one per tap. It wraps modulo 2^ADDR_W.
- R3: Bit 8 of `phase_sel` sets the direction. When the bit is 0, the coefficient address begins at `coef_base` and rises by one per tap. When the bit is 1, it begins at `coef_base` (the last tap of the phase) and falls by one per tap. Either way it wraps modulo 2^ADDR_W.
- R4: Each tap moves each address by exactly one word. Both read enables are high for exactly 20 consecutive cycles per output, and those cycles present 20 distinct consecutive addresses.
- R5: Samples and coefficients are signed 32-bit values. Each product is a full signed 64-bit value, and products are summed modulo 2^64.
- R6: `result` equals bits 53 down to 22 of the final 64-bit sum, which is the sum arithmetically shifted right by 22 and truncated to 32 bits. It holds until the next output.
- R7: The accumulator clears on every accepted start, so an output never depends on earlier outputs.
- R8: A `start` pulse while a computation is in progress, and `done` is low, is ignored.
- R9: All bits of `phase_sel` other than bit 8 have no effect.
- R10: After reset, `done`, both read enables and `result` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one output |
| phase_sel | input | 16 | Phase select word; bit 8 selects reverse tap order |
| data_base | input | 10 | First sample address |
| coef_base | input | 10 | First tap address (last tap of the phase in reverse mode) |
| data_rd_en | output | 1 | Sample memory read enable |
| data_addr | output | 10 | Sample memory read address |
| data_rd_data | input | 32 | Sample read data, one cycle after the address |
| coef_rd_en | output | 1 | Coefficient memory read enable |
| coef_addr | output | 10 | Coefficient memory read address |
| coef_rd_data | input | 32 | Coefficient read data, one cycle after the address |
| result | output | 32 | Scaled dot product |
| done | output | 1 | One-cycle pulse when `result` is updated |

## Verification
The bench records every address the engine issues and compares the sequence with the expected one.

- A design that applied both the increment and the decrement would show a frozen coefficient address.
- A design that ignored the direction flag would walk the wrong way.
- A design with an off-by-one in the tap counter would give 19 or 21 reads and a shifted done.

Extreme operands (all samples and taps at the most negative value) expose a product truncated to 32 bits or accumulated unsigned. Address runs that cross the top and bottom of memory catch broken wrap handling. A start back-to-back on `done` and a start mid-run catch an accumulator that is not cleared and a run that restarts when it should not. A run with every select bit set except bit 8 shows whether the other bits leak into the direction.

// File: rtl/fir_pkg.sv
package fir_pkg;
  // Tag travelling with each tap through the read and multiply stages
  typedef struct packed {
    logic valid;
    logic last;
  } tap_tag_t;
endpackage

// File: rtl/fir_addr_seq.sv
module fir_addr_seq
  import fir_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int NUM_TAPS = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic              reverse,
  input  logic [ADDR_W-1:0] data_base,
  input  logic [ADDR_W-1:0] coef_base,
  output logic              rd_en,
  output logic [ADDR_W-1:0] data_addr,
  output logic [ADDR_W-1:0] coef_addr,
  output tap_tag_t          tag
);
  localparam int CNT_W = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_TAPS - 1);

  logic             issuing;
  logic             dir_rev;
  logic [CNT_W-1:0] cnt;
  logic             at_last;

  assign at_last = (cnt == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      issuing   <= 1'b0;
      dir_rev   <= 1'b0;
      cnt       <= '0;
      data_addr <= '0;
      coef_addr <= '0;
    end else if (launch) begin
      issuing   <= 1'b1;
      dir_rev   <= reverse;
      cnt       <= '0;
      data_addr <= data_base;
      coef_addr <= coef_base;
    end else if (issuing) begin
      if (at_last) begin
        issuing <= 1'b0;
      end else begin
        cnt       <= cnt + 1'b1;
        data_addr <= data_addr + 1'b1;
        // a single adder whose operand is chosen: one step per tap, never both
        coef_addr <= coef_addr + (dir_rev ? {ADDR_W{1'b1}} : ADDR_W'(1));
      end
    end
  end

  assign rd_en     = issuing;
  assign tag.valid = issuing;
  assign tag.last  = issuing && at_last;

  // R2: data address steps up by one on every tap after the first
  p_data_step_r2: assert property (@(posedge clk) disable iff (rst)
    (issuing && $past(issuing)) |-> (data_addr == $past(data_addr) + 1'b1));

  // R3 / R4: coefficient address moves exactly one word in the chosen direction
  p_coef_step_r3: assert property (@(posedge clk) disable iff (rst)
    (issuing && $past(issuing) && dir_rev) |-> (coef_addr == $past(coef_addr) - 1'b1));
  p_coef_fwd_r3: assert property (@(posedge clk) disable iff (rst)
    (issuing && $past(issuing) && !dir_rev) |-> (coef_addr == $past(coef_addr) + 1'b1));

  // R4: the coefficient address never stalls inside a run
  p_no_stall_r4: assert property (@(posedge clk) disable iff (rst)
    (issuing && $past(issuing)) |-> (coef_addr != $past(coef_addr)));

  // R1: a run ends only after the last tap index was issued
  p_run_len_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(issuing) |-> ($past(cnt) == LAST_IDX));

  p_cnt_range_r1: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST_IDX);

  // R8: the top never relaunches while reads are still being issued
  p_no_relaunch_r8: assert property (@(posedge clk) disable iff (rst)
    launch |-> !issuing);
endmodule

// File: rtl/fir_mac_pipe.sv
module fir_mac_pipe
  import fir_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 64,
  parameter int SHIFT  = 22
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clear,
  input  tap_tag_t                 tag_in,
  input  logic signed [DATA_W-1:0] sample,
  input  logic signed [DATA_W-1:0] coef,
  output logic        [DATA_W-1:0] result,
  output logic                     done
);
  localparam int PROD_W = 2 * DATA_W;
  localparam int MSB    = SHIFT + DATA_W - 1;

  tap_tag_t                 tag_rd;
  tap_tag_t                 tag_mul;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  sum;

  // Stage 1: align the tag with the memory read latency
  always_ff @(posedge clk) begin
    if (rst) tag_rd <= '0;
    else     tag_rd <= tag_in;
  end

  // Stage 2: full-precision signed product
  always_ff @(posedge clk) begin
    if (rst) begin
      tag_mul <= '0;
      prod    <= '0;
    end else begin
      tag_mul <= tag_rd;
      if (tag_rd.valid) prod <= sample * coef;
    end
  end

  assign sum = acc + ACC_W'(prod);

  // Stage 3: accumulate and publish the scaled word
  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= tag_mul.valid && tag_mul.last;
      if (clear) begin
        acc <= '0;
      end else if (tag_mul.valid) begin
        acc <= sum;
        if (tag_mul.last) result <= sum[MSB:SHIFT];
      end
    end
  end

  // R1: done lasts one cycle
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: a clear never collides with a tap still in flight
  p_clear_idle_r7: assert property (@(posedge clk) disable iff (rst)
    clear |-> (!tag_mul.valid && !tag_rd.valid));

  // R6: result only changes together with done
  p_result_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));
endmodule

// File: rtl/fir_phase_mac.sv
module fir_phase_mac
  import fir_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ACC_W    = 64,
  parameter int ADDR_W   = 10,
  parameter int SEL_W    = 16,
  parameter int DIR_BIT  = 8,
  parameter int NUM_TAPS = 20,
  parameter int SHIFT    = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SEL_W-1:0]  phase_sel,
  input  logic [ADDR_W-1:0] data_base,
  input  logic [ADDR_W-1:0] coef_base,
  output logic              data_rd_en,
  output logic [ADDR_W-1:0] data_addr,
  input  logic [DATA_W-1:0] data_rd_data,
  output logic              coef_rd_en,
  output logic [ADDR_W-1:0] coef_addr,
  input  logic [DATA_W-1:0] coef_rd_data,
  output logic [DATA_W-1:0] result,
  output logic              done
);
  logic     busy;
  logic     launch;
  logic     rd_en;
  logic     unused_sel_bits;
  tap_tag_t tag_issue;

  // only the direction bit is decoded
  assign unused_sel_bits = ^phase_sel;

  assign launch = start && (!busy || done);

  always_ff @(posedge clk) begin
    if (rst)         busy <= 1'b0;
    else if (launch) busy <= 1'b1;
    else if (done)   busy <= 1'b0;
  end

  fir_addr_seq #(
    .ADDR_W   (ADDR_W),
    .NUM_TAPS (NUM_TAPS)
  ) i_seq (
    .clk       (clk),
    .rst       (rst),
    .launch    (launch),
    .reverse   (phase_sel[DIR_BIT]),
    .data_base (data_base),
    .coef_base (coef_base),
    .rd_en     (rd_en),
    .data_addr (data_addr),
    .coef_addr (coef_addr),
    .tag       (tag_issue)
  );

  assign data_rd_en = rd_en;
  assign coef_rd_en = rd_en;

  fir_mac_pipe #(
    .DATA_W (DATA_W),
    .ACC_W  (ACC_W),
    .SHIFT  (SHIFT)
  ) i_mac (
    .clk    (clk),
    .rst    (rst),
    .clear  (launch),
    .tag_in (tag_issue),
    .sample ($signed(data_rd_data)),
    .coef   ($signed(coef_rd_data)),
    .result (result),
    .done   (done)
  );

  // R1 / R8: done only appears inside an accepted run
  p_done_busy_r1: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);

  // R8: a start seen while busy and not done leaves the read stream untouched
  p_ignore_start_r8: assert property (@(posedge clk) disable iff (rst)
    (start && busy && !done && rd_en) |=> (data_addr == $past(data_addr) + 1'b1) || !rd_en);
endmodule

// File: tb/test_fir_phase_mac.sv
module test_fir_phase_mac;
  localparam int AW   = 10;
  localparam int MEMN = 1 << AW;
  localparam int TAPS = 20;
  localparam int LAT  = 23;

  typedef struct packed {
    int dbase;
    int cbase;
    int sel;
    int mode;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{0,    0,    32'h0000, 2},
    '{100,  63,   32'h0100, 2},
    '{1015, 19,   32'h0100, 0},
    '{200,  1010, 32'h0000, 0},
    '{300,  500,  32'hFEFF, 0},
    '{7,    40,   32'h01FF, 1},
    '{512,  1023, 32'h0100, 0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [15:0]   phase_sel = '0;
  logic [AW-1:0] data_base = '0;
  logic [AW-1:0] coef_base = '0;
  logic          data_rd_en, coef_rd_en, done;
  logic [AW-1:0] data_addr, coef_addr;
  logic [31:0]   data_rd_data = '0;
  logic [31:0]   coef_rd_data = '0;
  logic [31:0]   result;

  logic signed [31:0] dmem [MEMN];
  logic signed [31:0] cmem [MEMN];

  int rec_d [32];
  int rec_c [32];
  int n_seen = 0;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  fir_phase_mac i_fir_phase_mac (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .phase_sel    (phase_sel),
    .data_base    (data_base),
    .coef_base    (coef_base),
    .data_rd_en   (data_rd_en),
    .data_addr    (data_addr),
    .data_rd_data (data_rd_data),
    .coef_rd_en   (coef_rd_en),
    .coef_addr    (coef_addr),
    .coef_rd_data (coef_rd_data),
    .result       (result),
    .done         (done)
  );

  // memory models: synchronous read, one cycle latency
  always @(posedge clk) begin
    if (data_rd_en) data_rd_data <= dmem[data_addr];
    if (coef_rd_en) coef_rd_data <= cmem[coef_addr];
  end

  // record the issued address stream
  always @(posedge clk) begin
    if (start) n_seen <= 0;
    else if (data_rd_en && n_seen < 32) begin
      rec_d[n_seen] <= int'(data_addr);
      rec_c[n_seen] <= coef_rd_en ? int'(coef_addr) : -1;
      n_seen <= n_seen + 1;
    end
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic fill(input int seed, input int mode);
    for (int i = 0; i < MEMN; i++) begin
      case (mode)
        1: begin
          dmem[i] = 32'sh80000000;
          cmem[i] = 32'sh80000000;
        end
        2: begin
          dmem[i] = 32'(i - 500);
          cmem[i] = 32'((i % 7) << 22);
        end
        default: begin
          dmem[i] = 32'(i * 32'h9E3779B1) ^ 32'(seed * 32'h01000193);
          cmem[i] = 32'(i * 32'h85EBCA6B) ^ 32'(seed * 32'h27D4EB2F);
        end
      endcase
    end
  endtask

  function automatic int caddr(input int cb, input int sel, input int k);
    return sel[8] ? ((cb - k) & (MEMN - 1)) : ((cb + k) & (MEMN - 1));
  endfunction

  function automatic int expect_res(input int db, input int cb, input int sel);
    longint sum = 0;
    for (int k = 0; k < TAPS; k++) begin
      longint d = longint'(dmem[(db + k) & (MEMN - 1)]);
      longint c = longint'(cmem[caddr(cb, sel, k)]);
      sum += d * c;
    end
    return int'(sum >>> 22);
  endfunction

  // one output: returns edges until done (counting the accepting edge) and the result
  task automatic run(input int db, input int cb, input int sel, output int lat, output int res);
    int  n = 0;
    bit  got = 0;
    @(negedge clk);
    data_base = AW'(db);
    coef_base = AW'(cb);
    phase_sel = 16'(sel);
    start = 1'b1;
    while (n < 100 && !got) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      start = 1'b0;
      if (done) got = 1;
    end
    lat = got ? n : -1;
    res = int'(result);
  endtask

  task automatic check_addrs(input int db, input int cb, input int sel);
    int bad = 0;
    check("R4", "read count", n_seen, TAPS);
    for (int k = 0; k < TAPS; k++) begin
      if (rec_d[k] != ((db + k) & (MEMN - 1))) bad++;
    end
    check("R2", "data address mismatches", bad, 0);
    bad = 0;
    for (int k = 0; k < TAPS; k++) begin
      if (rec_c[k] != caddr(cb, sel, k)) bad++;
    end
    check("R3", "coef address mismatches", bad, 0);
  endtask

  initial begin
    int lat, res, r0, r1, exp_v, dones;
    fill(1, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10", "done after reset", done, 0);
    check("R10", "read enable after reset", data_rd_en | coef_rd_en, 0);
    check("R10", "result after reset", result, 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      fill(v + 3, VECS[v].mode);
      exp_v = expect_res(VECS[v].dbase, VECS[v].cbase, VECS[v].sel);
      run(VECS[v].dbase, VECS[v].cbase, VECS[v].sel, lat, res);
      check("R1", $sformatf("latency vec %0d", v), lat, LAT);
      check("R5", $sformatf("result vec %0d (R6)", v), res, exp_v);
      check_addrs(VECS[v].dbase, VECS[v].cbase, VECS[v].sel);
      @(negedge clk);
      check("R1", "done single cycle", done, 0);
      check("R6", "result held", int'(result), exp_v);
    end

    // R9: non-direction bits of the select word change nothing
    fill(7, 0);
    run(300, 500, 32'hFEFF, lat, r0);
    run(300, 500, 32'h0000, lat, r1);
    check("R9", "other select bits", r0, r1);
    run(300, 520, 32'hFFFF, lat, r0);
    run(300, 520, 32'h0100, lat, r1);
    check("R9", "other select bits reverse", r0, r1);

    // R7: back-to-back start on the done cycle, accumulator must clear
    fill(9, 0);
    exp_v = expect_res(40, 80, 0);
    run(40, 80, 0, lat, r0);
    data_base = AW'(40);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (lat < 100 && !done) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    check("R7", "back-to-back latency", lat, LAT);
    check("R7", "back-to-back result", int'(result), exp_v);

    // R8: start in the middle of a run is ignored
    exp_v = expect_res(60, 90, 32'h0100);
    @(negedge clk);
    data_base = AW'(60);
    coef_base = AW'(90);
    phase_sel = 16'h0100;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    data_base = AW'(700);
    coef_base = AW'(3);
    phase_sel = 16'h0000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dones = 0;
    lat = 7;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (done) begin
        dones++;
        if (dones == 1) begin
          lat = lat + i + 1;
          check("R8", "result after ignored start", int'(result), exp_v);
        end
      end
    end
    check("R8", "latency with ignored start", lat, LAT);
    check("R8", "single done", dones, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule